// File: doc/BRIEF.md
# Power-fail gated byte-wide static memory

This block is a byte-wide static memory that sits behind a supply-state machine. Three digital comparator flags describe the supply. The first says the supply is above the deselect threshold, the second says it is below that threshold, and the third says it has fallen under the battery switchover level. The controller merges these flags with active-low chip, output and write enables to pick one operating mode per cycle. It opens the array only while the supply is in tolerance and has been stable for a programmable number of clock edges.

Before the supply first reaches tolerance, the backup source stays disconnected and the block reports an isolated mode. Once power has been seen, a later drop under the switchover level selects the backup source. In that state the array keeps its contents and every pin is ignored. Accesses are single-cycle and whole-byte. A supply drop therefore stops a write in the same cycle, and a byte is never half-updated. The tri-state data bus is modelled as a read-data value plus a drive-enable flag.

Top module: `pwr_gated_sram`

## Requirements
- R1: With the supply usable and `ceN` high, `mode` reads 0 (standby), `rdOe` is 0 and no byte is written, whatever `oeN` and `weN` are.
- R2: With the supply usable, `ceN` low and `weN` low, `wrData` is stored at `addr` on the clock edge, whatever `oeN` is; `mode` reads 3 (write) and `rdOe` is 0.
- R3: With the supply usable, `ceN` low, `oeN` low and `weN` high, `mode` reads 2 (read), `rdOe` is 1 and, after that edge, `rdData` holds the byte stored at `addr`.
- R4: With the supply usable, `ceN` low and both `oeN` and `weN` high, `mode` reads 1 (active, bus released) and `rdOe` is 0.
- R5: Whenever `belowSwitch` is 0 and the flags are anything but `aboveDsel`=1 with `belowDsel`=0, `mode` reads 4 (power-fail deselect) and `rdOe` is 0. A write presented in that very cycle is dropped. Contradictory flags count as a failure.
- R6: Once armed, `belowSwitch`=1 gives `mode` 5 (backup) and `battSel` 1. All pins are ignored, and the array contents are intact when the supply returns.
- R7: From reset until the first edge with the supply in tolerance, `mode` reads 6 (isolated) and `battArmed` and `battSel` stay 0, even when `belowSwitch` is 1. `battArmed` is set on that first edge and then stays set until reset.
- R8: After any out-of-tolerance cycle, accesses are accepted only once the flags have shown in-tolerance on `STABLE_CYC`+1 consecutive edges; before that `mode` reads 4. Any bad cycle in between restarts the count.
- R9: The array holds 2^`ADDR_W` bytes of `DATA_W` bits, and the highest address is reachable.
- R10: `rdData` is 0 after reset and changes only on the edge that closes a read cycle. When the read address changes, the previous byte is shown until that edge, and the last byte read is held while no read occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, models a factory-fresh part |
| aboveDsel | input | 1 | Supply above deselect threshold |
| belowDsel | input | 1 | Supply below deselect threshold |
| belowSwitch | input | 1 | Supply below backup switchover level |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| wrData | input | DATA_W | Byte to store |
| rdData | output | DATA_W | Registered read byte |
| rdOe | output | 1 | Bus drive enable; 0 means high impedance |
| mode | output | 3 | Operating mode code |
| battSel | output | 1 | Backup source selected |
| battArmed | output | 1 | Backup isolation released |

## Verification
The bench probes the end of the recovery window. A write placed on the last rejected edge must leave the old byte in place, and one edge later the block must report the write mode. A design with an off-by-one counter would either accept the early write or stay locked too long. A one-cycle flag glitch partway through recovery is followed by writes that must all be rejected, so a counter that pauses instead of restarting shows up as a changed byte. Writes are presented in the very cycle the supply drops, in backup, with contradictory flags and with the chip deselected. A gate that lags by a register, or that trusts a single flag, corrupts bytes that are read back later. The bench also checks the isolated state under low supply after reset, the held read byte across an address change, and the top address.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

  typedef enum logic [2:0] {
    MODE_STANDBY  = 3'd0,
    MODE_IDLE     = 3'd1,
    MODE_READ     = 3'd2,
    MODE_WRITE    = 3'd3,
    MODE_PFAIL    = 3'd4,
    MODE_BACKUP   = 3'd5,
    MODE_ISOLATED = 3'd6
  } pgsMode_e;

  typedef enum logic [2:0] {
    ST_UNPOWERED = 3'd0,
    ST_BACKUP    = 3'd1,
    ST_PFAIL     = 3'd2,
    ST_RECOVER   = 3'd3,
    ST_ACTIVE    = 3'd4
  } pgsState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrStb;
    logic rdStb;
  } pgsStrobe_t;

endpackage

// File: rtl/pgs_ctrl.sv
module pgs_ctrl
  import pgs_pkg::*;
#(
  parameter int STABLE_CYC = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       aboveDsel,
  input  logic       belowDsel,
  input  logic       belowSwitch,
  input  logic       ceN,
  input  logic       oeN,
  input  logic       weN,
  output pgsStrobe_t stb,
  output logic [2:0] mode,
  output logic       rdOe,
  output logic       battSel,
  output logic       battArmed
);

  localparam int CNT_W = $clog2(STABLE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STABLE_CYC - 1);

  pgsState_e        state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             supGood;
  logic             accessOk;
  pgsMode_e         modeNow;

  // only the single consistent in-tolerance combination counts as good
  assign supGood = aboveDsel && !belowDsel && !belowSwitch;

  always_comb begin
    stateNext = state;
    cntNext   = '0;
    unique case (state)
      ST_UNPOWERED: begin
        if (supGood) stateNext = ST_RECOVER;
      end
      ST_ACTIVE, ST_PFAIL, ST_BACKUP: begin
        if (belowSwitch)   stateNext = ST_BACKUP;
        else if (!supGood) stateNext = ST_PFAIL;
        else if (state != ST_ACTIVE) stateNext = ST_RECOVER;
      end
      ST_RECOVER: begin
        if (belowSwitch)   stateNext = ST_BACKUP;
        else if (!supGood) stateNext = ST_PFAIL;
        else if (cnt == CNT_LAST) stateNext = ST_ACTIVE;
        else cntNext = cnt + CNT_W'(1);
      end
      default: stateNext = ST_UNPOWERED;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_UNPOWERED;
      cnt       <= '0;
      battArmed <= 1'b0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
      if (supGood) battArmed <= 1'b1;
    end
  end

  // same-cycle gating: a flag drop blocks the access on the cycle it appears
  assign accessOk = (state == ST_ACTIVE) && supGood;

  always_comb begin
    if (state == ST_UNPOWERED)  modeNow = MODE_ISOLATED;
    else if (belowSwitch)       modeNow = MODE_BACKUP;
    else if (!accessOk)         modeNow = MODE_PFAIL;
    else if (ceN)               modeNow = MODE_STANDBY;
    else if (!weN)              modeNow = MODE_WRITE;
    else if (!oeN)              modeNow = MODE_READ;
    else                        modeNow = MODE_IDLE;
  end

  assign mode      = modeNow;
  assign stb.wrStb = (modeNow == MODE_WRITE);
  assign stb.rdStb = (modeNow == MODE_READ);
  assign rdOe      = stb.rdStb;
  assign battSel   = battArmed && belowSwitch;

endmodule

// File: rtl/pgs_datapath.sv
module pgs_datapath
  import pgs_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pgsStrobe_t        stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // whole-byte store in one edge: no partial update is possible
  always_ff @(posedge clk) begin
    if (stb.wrStb) mem[addr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdData <= '0;
    else if (stb.rdStb) rdData <= mem[addr];
  end

endmodule

// File: rtl/pwr_gated_sram.sv
module pwr_gated_sram
  import pgs_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 8,
  parameter int STABLE_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aboveDsel,
  input  logic              belowDsel,
  input  logic              belowSwitch,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdOe,
  output logic [2:0]        mode,
  output logic              battSel,
  output logic              battArmed
);

  pgsStrobe_t stb;

  pgs_ctrl #(.STABLE_CYC(STABLE_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .aboveDsel(aboveDsel), .belowDsel(belowDsel), .belowSwitch(belowSwitch),
    .ceN(ceN), .oeN(oeN), .weN(weN),
    .stb(stb), .mode(mode), .rdOe(rdOe),
    .battSel(battSel), .battArmed(battArmed)
  );

  pgs_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .addr(addr), .wrData(wrData), .rdData(rdData)
  );

endmodule

// File: rtl/pwr_gated_sram_chk.sv
module pwr_gated_sram_chk
  import pgs_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       aboveDsel,
  input logic       belowDsel,
  input logic       belowSwitch,
  input logic       ceN,
  input logic       oeN,
  input logic       weN,
  input logic       rdOe,
  input logic [2:0] mode,
  input logic       battSel,
  input logic       battArmed
);

  logic good;
  assign good = aboveDsel && !belowDsel && !belowSwitch;

  assert_ce_high_hiz_R1: assert property (@(posedge clk) disable iff (!rstN)
    ceN |-> !rdOe);

  assert_write_no_drive_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && !weN) |-> !rdOe);

  assert_read_needs_pins_R3: assert property (@(posedge clk) disable iff (!rstN)
    rdOe |-> (!ceN && !oeN && weN && good));

  assert_idle_hiz_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && oeN && weN) |-> !rdOe);

  assert_fail_deselect_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!belowSwitch && !good && battArmed) |-> (!rdOe && mode == MODE_PFAIL));

  assert_backup_select_R6: assert property (@(posedge clk) disable iff (!rstN)
    (belowSwitch && battArmed) |-> (battSel && !rdOe && mode == MODE_BACKUP));

  assert_armed_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(battArmed) |-> battArmed);

  assert_isolated_no_batt_R7: assert property (@(posedge clk) disable iff (!rstN)
    !battArmed |-> (!battSel && mode == MODE_ISOLATED));

  assert_access_after_good_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdOe || mode == MODE_WRITE) |-> $past(good));

endmodule

bind pwr_gated_sram pwr_gated_sram_chk u_chk (
  .clk(clk), .rstN(rstN),
  .aboveDsel(aboveDsel), .belowDsel(belowDsel), .belowSwitch(belowSwitch),
  .ceN(ceN), .oeN(oeN), .weN(weN),
  .rdOe(rdOe), .mode(mode), .battSel(battSel), .battArmed(battArmed)
);

// File: tb/sim_pwr_gated_sram.sv
module sim_pwr_gated_sram;

  localparam int PERIOD = 10;
  localparam int AW     = 10;
  localparam int DW     = 8;
  localparam int STABLE = 4;
  localparam logic [AW-1:0] MAXA = '1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          aboveDsel = 1'b0, belowDsel = 1'b1, belowSwitch = 1'b1;
  logic          ceN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic          rdOe;
  logic [2:0]    mode;
  logic          battSel, battArmed;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct {
    int          due;
    logic [DW-1:0] data;
    string       tag;
  } item_t;
  item_t sbQ[$];

  pwr_gated_sram #(.ADDR_W(AW), .DATA_W(DW), .STABLE_CYC(STABLE)) u0 (
    .clk(clk), .rstN(rstN),
    .aboveDsel(aboveDsel), .belowDsel(belowDsel), .belowSwitch(belowSwitch),
    .ceN(ceN), .oeN(oeN), .weN(weN), .addr(addr), .wrData(wrData),
    .rdData(rdData), .rdOe(rdOe), .mode(mode),
    .battSel(battSel), .battArmed(battArmed)
  );

  always #(PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chkEq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compares scoreboard items once their edge has passed
  always @(negedge clk) begin
    while (sbQ.size() > 0 && sbQ[0].due <= cyc) begin
      item_t it;
      it = sbQ.pop_front();
      chkEq(it.tag, int'(rdData), int'(it.data));
    end
  end

  task automatic adv();
    @(negedge clk);
    #1;
  endtask

  task automatic setSup(logic a, logic b, logic s);
    aboveDsel = a; belowDsel = b; belowSwitch = s;
  endtask

  task automatic pins(logic c, logic o, logic w, logic [AW-1:0] a, logic [DW-1:0] d);
    ceN = c; oeN = o; weN = w; addr = a; wrData = d;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d, logic o);
    pins(1'b0, o, 1'b0, a, d);
    adv();
    chkEq("R2 mode", int'(mode), 3);
    chkEq("R2 rdOe", int'(rdOe), 0);
  endtask

  task automatic rd(logic [AW-1:0] a, logic [DW-1:0] e, string tag);
    pins(1'b0, 1'b0, 1'b1, a, '0);
    sbQ.push_back('{due: cyc + 1, data: e, tag: tag});
    adv();
    chkEq("R3 rdOe", int'(rdOe), 1);
    chkEq("R3 mode", int'(mode), 2);
  endtask

  initial begin
    #(PERIOD * 20000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R7: reset with supply below switchover, never powered
    repeat (3) adv();
    rstN = 1'b1;
    adv();
    chkEq("R7 mode isolated", int'(mode), 6);
    chkEq("R7 battArmed", int'(battArmed), 0);
    chkEq("R7 battSel", int'(battSel), 0);
    chkEq("R10 rdData reset", int'(rdData), 0);
    chkEq("R1 rdOe reset", int'(rdOe), 0);

    // first power-up: recovery window
    setSup(1'b1, 1'b0, 1'b0);
    adv();
    chkEq("R7 armed on first good edge", int'(battArmed), 1);
    chkEq("R8 recovering", int'(mode), 4);
    repeat (STABLE - 1) adv();
    chkEq("R8 still recovering", int'(mode), 4);
    adv();
    chkEq("R1 standby", int'(mode), 0);

    wr(10'd3, 8'h5A, 1'b1);
    wr(10'd4, 8'hC3, 1'b0);
    wr(MAXA, 8'h7E, 1'b1);

    rd(10'd3, 8'h5A, "R3 read addr3");
    // R10: address change, old byte held until the edge
    pins(1'b0, 1'b0, 1'b1, 10'd4, '0);
    #1;
    chkEq("R10 hold on addr change", int'(rdData), 8'h5A);
    sbQ.push_back('{due: cyc + 1, data: 8'hC3, tag: "R10 new byte next edge"});
    adv();
    rd(MAXA, 8'h7E, "R9 top address");

    // R4: active, bus released
    pins(1'b0, 1'b1, 1'b1, 10'd3, '0);
    adv();
    chkEq("R4 mode idle", int'(mode), 1);
    chkEq("R4 rdOe", int'(rdOe), 0);
    chkEq("R10 held while not reading", int'(rdData), 8'h7E);

    // R1: deselected write attempt
    pins(1'b1, 1'b0, 1'b0, 10'd3, 8'h00);
    adv();
    chkEq("R1 mode standby", int'(mode), 0);
    chkEq("R1 rdOe", int'(rdOe), 0);
    rd(10'd3, 8'h5A, "R1 deselected write ignored");

    // R5: flag drop in the same cycle as a write
    setSup(1'b0, 1'b1, 1'b0);
    pins(1'b0, 1'b1, 1'b0, 10'd3, 8'hFF);
    adv();
    chkEq("R5 mode pfail", int'(mode), 4);
    pins(1'b0, 1'b0, 1'b1, 10'd3, '0);
    adv();
    chkEq("R5 read blocked", int'(rdOe), 0);
    setSup(1'b1, 1'b1, 1'b0);
    pins(1'b0, 1'b1, 1'b0, 10'd4, 8'hEE);
    adv();
    chkEq("R5 contradictory flags", int'(mode), 4);

    // R6: backup, inputs ignored
    setSup(1'b0, 1'b1, 1'b1);
    pins(1'b0, 1'b1, 1'b0, 10'd4, 8'h00);
    adv();
    chkEq("R6 mode backup", int'(mode), 5);
    chkEq("R6 battSel", int'(battSel), 1);
    pins(1'b0, 1'b0, 1'b1, 10'd4, '0);
    adv();
    chkEq("R6 rdOe", int'(rdOe), 0);

    // R8: glitch during recovery restarts the count
    pins(1'b1, 1'b1, 1'b1, '0, '0);
    setSup(1'b1, 1'b0, 1'b0);
    repeat (STABLE) adv();
    setSup(1'b0, 1'b1, 1'b0);
    adv();
    setSup(1'b1, 1'b0, 1'b0);
    pins(1'b0, 1'b1, 1'b0, 10'd4, 8'h99);
    repeat (STABLE) adv();
    chkEq("R8 window not yet open", int'(mode), 4);
    adv();
    chkEq("R8 active after STABLE+1 edges", int'(mode), 3);
    rd(10'd4, 8'hC3, "R8 recovery writes rejected");
    rd(10'd3, 8'h5A, "R6 contents retained");

    wr(10'd4, 8'h99, 1'b1);
    rd(10'd4, 8'h99, "R2 rewrite after recovery");

    pins(1'b1, 1'b1, 1'b1, '0, '0);
    repeat (3) adv();
    chkEq("scoreboard drained", sbQ.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule